// File: doc/BRIEF.md
# Three-Channel Converter Bus Front End

This block is the digital side of a three-channel, 8-bit voltage converter that is loaded over a parallel bus. An external master presents a channel address, a data byte and an active-low write strobe. All three are asynchronous to the system clock, so they are brought into the clock domain through a common synchronizer. The block then steers the byte into one of three code registers, or treats the write as a power-down command.

Each channel exposes its stored code and an output-enable that stands for the analog buffer driving its pin. Writing the spare address turns all three buffers off. The codes stay stored. A later write to a real channel turns the buffers back on. After power-up, and again after every wake-up, a timer sized from the clock frequency holds a ready flag low for the output stabilisation time. That time is 13 µs by default, which is 1300 cycles at 100 MHz.

Top module: `tri_dac_front`

## Requirements
- R1: Address 0 writes channel A (`code_o[0]`), address 1 writes channel B (`code_o[1]`) and address 2 writes channel C (`code_o[2]`). Address 3 writes no code register.
- R2: Strobe, address and data each pass through two synchronizer flops. A code register takes new data on the third rising clock edge after the strobe falls.
- R3: While the synchronized strobe is low, the addressed register follows the data bus on every clock cycle (transparent write).
- R4: While the strobe is high, no code register changes, whatever the data and address buses do. This includes a data change made in the same cycle as the strobe rises.
- R5: A write to address 3 enters shutdown. All three enables in `en_o` go to 0 together and `ready_o` goes low. No stored code changes.
- R6: A write to address 3 while already in shutdown has no effect. The block stays in shutdown.
- R7: A write to address 0, 1 or 2 during shutdown leaves shutdown. It sets `en_o` to 3'b111 and also loads that channel with the data byte.
- R8: Codes of channels that are not written keep their pre-shutdown values through shutdown and wake-up.
- R9: Reset clears all three codes to 8'h00, sets `en_o` to 3'b111 (active, not shut down) and drives `ready_o` low.
- R10: `ready_o` rises exactly SETTLE cycles after reset release, or after the edge on which a wake-up takes effect. SETTLE is the ceiling of CLK_HZ × SETTLE_NS / 1e9, which is 1300 by default. A write to a channel while the block is awake does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Asynchronous active-low write strobe |
| addr_i | input | 2 | Channel address; the value 3 is the shutdown command |
| data_i | input | 8 | Data byte |
| code_o | output | 3x8 | Stored code per channel, index 0 = A |
| en_o | output | 3 | Per-channel output enable, low while shut down |
| ready_o | output | 1 | High once outputs have settled after reset or wake-up |

## Verification
The power state is visible at once. If shutdown is wrongly entered or left, all three enables flip on the next edge, and the enables are checked to move only as one group. A wrong settle count only shows when `ready_o` rises. It is therefore measured against an independent cycle counter in both directions, so a rise that is early or late by even one cycle is caught. A corrupted code register shows on `code_o` three edges after the write that caused it. Codes that drift during shutdown or while the strobe is idle are caught on the cycle they change.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    typedef enum logic {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_state_e;

    // Number of clock cycles that cover settle_ns, rounded up, never below one.
    function automatic int unsigned settle_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned settle_ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = clk_hz * settle_ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) begin
            cyc = 1;
        end
        return int'(cyc);
    endfunction

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_sel,
    output logic              off_cmd
);

    localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign ch_sel[c] = !wr_n && (addr == ADDR_W'(c));
    end

    assign off_cmd = !wr_n && (addr == OFF_ADDR);

endmodule

// File: rtl/dac_fe_chan.sv
module dac_fe_chan #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] code
);

    logic [DATA_W-1:0] code_d;
    logic [DATA_W-1:0] code_q;

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/dac_fe_power.sv
module dac_fe_power
    import dac_fe_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_cmd,
    input  logic wake_cmd,
    output logic shut,
    output logic ready
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYC);

    typedef struct packed {
        pwr_state_e       pwr;
        logic [CNT_W-1:0] cnt;
    } pwr_reg_t;

    pwr_reg_t st_d;
    pwr_reg_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.pwr)
            PWR_ON: begin
                if (off_cmd) begin
                    st_d.pwr = PWR_OFF;
                    st_d.cnt = '0;
                end else if (st_q.cnt != CNT_END) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PWR_OFF: begin
                if (wake_cmd) begin
                    st_d.pwr = PWR_ON;
                    st_d.cnt = '0;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pwr: PWR_ON, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign shut  = (st_q.pwr == PWR_OFF);
    assign ready = (st_q.pwr == PWR_ON) && (st_q.cnt == CNT_END);

endmodule

// File: rtl/tri_dac_front.sv
module tri_dac_front
    import dac_fe_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned SETTLE_NS   = 13_000,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ADDR_W     = $clog2(NUM_CH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_n_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              data_i,
    output logic [NUM_CH-1:0][DATA_W-1:0]  code_o,
    output logic [NUM_CH-1:0]              en_o,
    output logic                           ready_o
);

    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_NS);
    localparam int unsigned BUS_W      = 1 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0]  bus_raw;
    logic [BUS_W-1:0]  bus_sync;
    logic              wr_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [NUM_CH-1:0] ch_sel;
    logic              off_cmd;
    logic              shut;
    logic              ready;

    assign bus_raw = {wr_n_i, addr_i, data_i};

    dac_fe_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_raw),
        .dout (bus_sync)
    );

    assign {wr_n_s, addr_s, data_s} = bus_sync;

    dac_fe_decode #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .wr_n   (wr_n_s),
        .addr   (addr_s),
        .ch_sel (ch_sel),
        .off_cmd(off_cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_fe_chan #(
            .DATA_W(DATA_W)
        ) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .load (ch_sel[c]),
            .data (data_s),
            .code (code_o[c])
        );
    end

    dac_fe_power #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .off_cmd (off_cmd),
        .wake_cmd(|ch_sel),
        .shut    (shut),
        .ready   (ready)
    );

    assign en_o    = {NUM_CH{!shut}};
    assign ready_o = ready;

endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker
    import dac_fe_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned SETTLE_NS   = 13_000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_n_i,
    input logic [ADDR_W-1:0]             addr_i,
    input logic [DATA_W-1:0]             data_i,
    input logic [NUM_CH-1:0][DATA_W-1:0] code_o,
    input logic [NUM_CH-1:0]             en_o,
    input logic                          ready_o
);

    localparam int unsigned SETTLE = settle_cycles(CLK_HZ, SETTLE_NS);
    localparam int unsigned MON_W  = $clog2(SETTLE + 1);
    localparam logic [MON_W-1:0] MON_END = MON_W'(SETTLE);

    logic [MON_W-1:0]     mon_q;
    logic [SYNC_STAGES:0] hist_q;
    logic                 all_on;
    logic                 all_off;

    assign all_on  = (en_o == {NUM_CH{1'b1}});
    assign all_off = (en_o == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q  <= '0;
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[SYNC_STAGES-1:0], wr_n_i};
            if (!all_on) begin
                mon_q <= '0;
            end else if (mon_q != MON_END) begin
                mon_q <= mon_q + 1'b1;
            end
        end
    end

    assert_en_grouped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_on || all_off);

    assert_off_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> !ready_o);

    assert_wake_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o[0]) |-> !ready_o);

    assert_ready_late_enough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (mon_q == MON_END));

    assert_ready_not_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mon_q == MON_END) && all_on) |-> ready_o);

    assert_codes_kept_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && $past(all_off)) |-> $stable(code_o));

    assert_idle_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&hist_q) |=> $stable(code_o));

endmodule

bind tri_dac_front dac_fe_checker #(
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .CLK_HZ     (CLK_HZ),
    .SETTLE_NS  (SETTLE_NS),
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W     (ADDR_W)
) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_n_i (wr_n_i),
    .addr_i (addr_i),
    .data_i (data_i),
    .code_o (code_o),
    .en_o   (en_o),
    .ready_o(ready_o)
);

// File: tb/test_tri_dac_front.sv
`timescale 1ns/1ps
module test_tri_dac_front;

    // 100 MHz clock, 13 us settle -> 1300 cycles, worked out by hand
    localparam int SETTLE = 1300;
    localparam int NVEC   = 10;

    // {addr[2], data[8], expA[8], expB[8], expC[8], expEn[1]}
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 8'h5A, 8'h5A, 8'h00, 8'h00, 1'b1},
        {2'd1, 8'hC3, 8'h5A, 8'hC3, 8'h00, 1'b1},
        {2'd2, 8'hFF, 8'h5A, 8'hC3, 8'hFF, 1'b1},
        {2'd0, 8'h01, 8'h01, 8'hC3, 8'hFF, 1'b1},
        {2'd3, 8'h77, 8'h01, 8'hC3, 8'hFF, 1'b0}, // shutdown, data ignored
        {2'd3, 8'h22, 8'h01, 8'hC3, 8'hFF, 1'b0}, // R6 repeated shutdown
        {2'd1, 8'h80, 8'h01, 8'h80, 8'hFF, 1'b1}, // R7 wake + load, R8 A/C kept
        {2'd3, 8'h00, 8'h01, 8'h80, 8'hFF, 1'b0},
        {2'd2, 8'h3C, 8'h01, 8'h80, 8'h3C, 1'b1},
        {2'd0, 8'h00, 8'h00, 8'h80, 8'h3C, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_n_i = 1'b1;
    logic [1:0]       addr_i = '0;
    logic [7:0]       data_i = '0;
    logic [2:0][7:0]  code_o;
    logic [2:0]       en_o;
    logic             ready_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tri_dac_front i_tri_dac_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n_i (wr_n_i),
        .addr_i (addr_i),
        .data_i (data_i),
        .code_o (code_o),
        .en_o   (en_o),
        .ready_o(ready_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // full write cycle: strobe low for three edges, then idle until settled
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a;
        data_i = d;
        wr_n_i = 1'b0;
        repeat (3) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 code A", 32'(code_o[0]), 32'h00);
        chk("R9 code B", 32'(code_o[1]), 32'h00);
        chk("R9 code C", 32'(code_o[2]), 32'h00);
        chk("R9 en",     32'(en_o), 32'h7);
        chk("R9 ready",  32'(ready_o), 32'h0);

        // R10 ready after reset release
        rst_n = 1'b1;
        repeat (SETTLE - 1) @(posedge clk);
        @(negedge clk);
        chk("R10 ready one cycle early", 32'(ready_o), 32'h0);
        @(negedge clk);
        chk("R10 ready on time", 32'(ready_o), 32'h1);

        // R2 latency: change lands on the third edge
        @(negedge clk);
        addr_i = 2'd2;
        data_i = 8'h96;
        wr_n_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 not yet after two edges", 32'(code_o[2]), 32'h00);
        @(negedge clk);
        chk("R2 loaded on third edge", 32'(code_o[2]), 32'h96);
        chk("R10 ready not restarted by awake write", 32'(ready_o), 32'h1);
        wr_n_i = 1'b1;
        repeat (3) @(negedge clk);

        // R3 transparency: strobe held low, data changes are followed
        addr_i = 2'd1;
        data_i = 8'h11;
        wr_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 follow first", 32'(code_o[1]), 32'h11);
        data_i = 8'h22;
        repeat (3) @(negedge clk);
        chk("R3 follow second", 32'(code_o[1]), 32'h22);
        data_i = 8'h33;
        repeat (3) @(negedge clk);
        chk("R3 follow third", 32'(code_o[1]), 32'h33);
        // R4 strobe rises together with a data change: old value kept
        wr_n_i = 1'b1;
        data_i = 8'hEE;
        repeat (5) @(negedge clk);
        chk("R4 hold on release", 32'(code_o[1]), 32'h33);
        // R4 bus activity with strobe high
        addr_i = 2'd0;
        data_i = 8'h5C;
        repeat (5) @(negedge clk);
        chk("R4 idle A", 32'(code_o[0]), 32'h00);
        chk("R4 idle B", 32'(code_o[1]), 32'h33);
        chk("R4 idle C", 32'(code_o[2]), 32'h96);
        // R1 address 3 writes no code register
        bus_write(2'd3, 8'hAB);
        chk("R1 addr3 A", 32'(code_o[0]), 32'h00);
        chk("R1 addr3 B", 32'(code_o[1]), 32'h33);
        chk("R1 addr3 C", 32'(code_o[2]), 32'h96);
        chk("R5 shutdown en", 32'(en_o), 32'h0);
        chk("R5 shutdown ready", 32'(ready_o), 32'h0);

        // R7 + R10 wake timing
        @(negedge clk);
        addr_i = 2'd0;
        data_i = 8'hAA;
        wr_n_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 wake en", 32'(en_o), 32'h7);
        chk("R7 wake load A", 32'(code_o[0]), 32'hAA);
        chk("R8 B kept over shutdown", 32'(code_o[1]), 32'h33);
        chk("R8 C kept over shutdown", 32'(code_o[2]), 32'h96);
        chk("R10 ready low at wake", 32'(ready_o), 32'h0);
        wr_n_i = 1'b1;
        repeat (SETTLE - 1) @(negedge clk);
        chk("R10 wake ready one cycle early", 32'(ready_o), 32'h0);
        @(negedge clk);
        chk("R10 wake ready on time", 32'(ready_o), 32'h1);

        // reset back to a clean start for the vector table
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 re-reset code A", 32'(code_o[0]), 32'h00);
        rst_n = 1'b1;

        // table walk: R1 decode, R5..R8 shutdown behaviour
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][34:33], VEC[i][32:25]);
            chk("R1 vec code A", 32'(code_o[0]), 32'(VEC[i][24:17]));
            chk("R1 vec code B", 32'(code_o[1]), 32'(VEC[i][16:9]));
            chk("R1 vec code C", 32'(code_o[2]), 32'(VEC[i][8:1]));
            chk("R5 vec enables", 32'(en_o), VEC[i][0] ? 32'h7 : 32'h0);
        end

        // R6 repeated shutdown leaves block off; R7 wake still works
        bus_write(2'd3, 8'h00);
        bus_write(2'd3, 8'h00);
        chk("R6 still shut", 32'(en_o), 32'h0);
        chk("R6 still not ready", 32'(ready_o), 32'h0);
        bus_write(2'd2, 8'h42);
        chk("R7 wake en after double off", 32'(en_o), 32'h7);
        chk("R7 wake load C", 32'(code_o[2]), 32'h42);
        chk("R8 A kept", 32'(code_o[0]), 32'h00);
        chk("R8 B kept", 32'(code_o[1]), 32'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule